// File: doc/BRIEF.md
# AXI4 to AXI3 Master Adapter

This block joins a master that speaks AXI4 (for example a DMA engine that moves memory to a stream or a stream to memory) to a slave port that only understands AXI3. All five channels go through it. Valid and ready travel combinationally, so the adapter adds no latency. Only the fields whose meaning differs between the two protocol versions are rewritten. The burst length is cut to the four-bit AXI3 range. The lock field is widened to two bits and held at normal access. The cache attributes are translated. A write-data ID is generated for every write beat.

The adapter never splits a long burst. The upstream master must already keep its bursts to 16 beats or fewer. An accepted request that breaks this rule has its length clamped to 16 beats and sets a sticky error flag. The flag is held by a two-state machine. `ERR_CLEAR` is the reset state. An accepted oversize request on either address channel moves it to `ERR_LATCHED`. That state is only left by reset.

The write-data ID comes from a small FIFO of accepted write IDs. Every accepted write address pushes its ID. The handshake of the last beat of a write burst pops the head. The write-address channel is held off while the FIFO is full. The write-data channel is held off while the FIFO is empty, because the ID of the data is then not yet known.

Top module: `axi4_to_axi3_adapter`

## Requirements
- R1: Outgoing AWLEN/ARLEN equals the low four bits of the incoming length when that length is 15 or less. When the incoming length is 16 or more, the outgoing length is 15.
- R2: `len_err` is 0 after reset. It is 1 from the cycle after an accepted AW or AR handshake whose incoming length is above 15, and it stays 1 until the next reset.
- R3: `m_awlock` and `m_arlock` are always 2'b00.
- R4: Outgoing cache bits [1:0] equal the incoming bits [1:0]. Outgoing bits [3:2] equal the incoming bits [3:2] when incoming bit 1 is 1, and are 2'b00 when incoming bit 1 is 0.
- R5: `m_wid` equals the AWID of the write burst that the beat belongs to. Bursts are matched to write addresses in the order the addresses were accepted. A burst ends on the handshake of a beat with `s_wlast` = 1.
- R6: While WID_DEPTH write bursts have been accepted and have not completed, `m_awvalid` and `s_awready` are both 0. They return once a burst completes.
- R7: While no accepted write burst is outstanding, `m_wvalid` and `s_wready` are both 0.
- R8: Outside the rewritten fields, the adapter forwards the ID, address, size and burst fields, and the write data, strobe and last. The B and R channels pass through unchanged in both directions.
- R9: AR valid and ready pass straight through and are never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | ID_W | AXI4 write address ID |
| s_awaddr | input | ADDR_W | AXI4 write address |
| s_awlen | input | 8 | AXI4 write burst length minus one |
| s_awsize | input | 3 | Write beat size |
| s_awburst | input | 2 | Write burst type |
| s_awcache | input | 4 | AXI4 write cache attributes |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wlast | input | 1 | Last write beat |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_arid | input | ID_W | AXI4 read address ID |
| s_araddr | input | ADDR_W | AXI4 read address |
| s_arlen | input | 8 | AXI4 read burst length minus one |
| s_arsize | input | 3 | Read beat size |
| s_arburst | input | 2 | Read burst type |
| s_arcache | input | 4 | AXI4 read cache attributes |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rlast | output | 1 | Last read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| m_awid | output | ID_W | AXI3 write address ID |
| m_awaddr | output | ADDR_W | AXI3 write address |
| m_awlen | output | 4 | AXI3 write burst length minus one |
| m_awsize | output | 3 | Write beat size |
| m_awburst | output | 2 | Write burst type |
| m_awlock | output | 2 | AXI3 write lock, always normal |
| m_awcache | output | 4 | AXI3 write cache attributes |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wid | output | ID_W | AXI3 write data ID |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bid | input | ID_W | Write response ID |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_arid | output | ID_W | AXI3 read address ID |
| m_araddr | output | ADDR_W | AXI3 read address |
| m_arlen | output | 4 | AXI3 read burst length minus one |
| m_arsize | output | 3 | Read beat size |
| m_arburst | output | 2 | Read burst type |
| m_arlock | output | 2 | AXI3 read lock, always normal |
| m_arcache | output | 4 | AXI3 read cache attributes |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rid | input | ID_W | Read data ID |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| len_err | output | 1 | Sticky flag: an oversize burst was accepted |

## Verification
The checker counts outstanding write bursts from the handshakes seen at the ports. On every cycle it confirms that the write address stalls at a full count and the write data stalls at a zero count. It also confirms on every cycle that lengths are clamped or passed correctly, that a clear modifiable bit forces the allocate bits to zero, that the error flag sets after an oversize handshake and never drops, and that the WID holds steady while a beat waits. Only the bench scenarios show that each burst gets the right WID in acceptance order: the scoreboard checks this while data arrives ahead of its address and while the FIFO fills to its limit. The scenarios also show that a request held without ready leaves the flag clear, and that a second reset clears it.

// File: rtl/axi_adapt_pkg.sv
package axi_adapt_pkg;

    localparam int unsigned AXI3_LEN_W   = 4;
    localparam int unsigned AXI4_LEN_W   = 8;
    localparam logic [AXI3_LEN_W-1:0] AXI3_LEN_MAX = '1;

    typedef enum logic {
        ERR_CLEAR   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_t;

    // Allocate hints only carry meaning for modifiable transactions.
    function automatic logic [3:0] cache_v4_to_v3(input logic [3:0] c);
        return {(c[1] ? c[3:2] : 2'b00), c[1:0]};
    endfunction

endpackage

// File: rtl/axi_ax_convert.sv
module axi_ax_convert
    import axi_adapt_pkg::*;
(
    input  logic [AXI4_LEN_W-1:0] len_in,
    input  logic [3:0]            cache_in,
    output logic [AXI3_LEN_W-1:0] len_out,
    output logic [3:0]            cache_out,
    output logic                  oversize
);

    localparam logic [AXI4_LEN_W-1:0] LIMIT = AXI4_LEN_W'(AXI3_LEN_MAX);

    always_comb begin
        oversize  = (len_in > LIMIT);
        len_out   = oversize ? AXI3_LEN_MAX : len_in[AXI3_LEN_W-1:0];
        cache_out = cache_v4_to_v3(cache_in);
    end

endmodule

// File: rtl/axi_id_fifo.sv
module axi_id_fifo #(
    parameter int unsigned ID_W  = 4,
    parameter int unsigned DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            full,
    output logic            empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [ID_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] used;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_id;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

    assign head_id = slots[rd_ptr];
    assign full    = (used == CNT_W'(DEPTH));
    assign empty   = (used == '0);

endmodule

// File: rtl/axi4_to_axi3_adapter.sv
module axi4_to_axi3_adapter
    import axi_adapt_pkg::*;
#(
    parameter int unsigned ID_W      = 4,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WID_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ID_W-1:0]       s_awid,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic [7:0]            s_awlen,
    input  logic [2:0]            s_awsize,
    input  logic [1:0]            s_awburst,
    input  logic [3:0]            s_awcache,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [DATA_W-1:0]     s_wdata,
    input  logic [DATA_W/8-1:0]   s_wstrb,
    input  logic                  s_wlast,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    output logic [ID_W-1:0]       s_bid,
    output logic [1:0]            s_bresp,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    input  logic [ID_W-1:0]       s_arid,
    input  logic [ADDR_W-1:0]     s_araddr,
    input  logic [7:0]            s_arlen,
    input  logic [2:0]            s_arsize,
    input  logic [1:0]            s_arburst,
    input  logic [3:0]            s_arcache,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    output logic [ID_W-1:0]       s_rid,
    output logic [DATA_W-1:0]     s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rlast,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    output logic [ID_W-1:0]       m_awid,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [3:0]            m_awlen,
    output logic [2:0]            m_awsize,
    output logic [1:0]            m_awburst,
    output logic [1:0]            m_awlock,
    output logic [3:0]            m_awcache,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [ID_W-1:0]       m_wid,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    output logic                  m_wlast,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    input  logic [ID_W-1:0]       m_bid,
    input  logic [1:0]            m_bresp,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    output logic [ID_W-1:0]       m_arid,
    output logic [ADDR_W-1:0]     m_araddr,
    output logic [3:0]            m_arlen,
    output logic [2:0]            m_arsize,
    output logic [1:0]            m_arburst,
    output logic [1:0]            m_arlock,
    output logic [3:0]            m_arcache,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    input  logic [ID_W-1:0]       m_rid,
    input  logic [DATA_W-1:0]     m_rdata,
    input  logic [1:0]            m_rresp,
    input  logic                  m_rlast,
    input  logic                  m_rvalid,
    output logic                  m_rready,
    output logic                  len_err
);

    logic aw_oversize, ar_oversize;
    logic fifo_full, fifo_empty;
    logic aw_fire, ar_fire, w_done;
    err_state_t err_q, err_d;

    // Address-channel field conversion
    axi_ax_convert u_aw_conv (
        .len_in    (s_awlen),
        .cache_in  (s_awcache),
        .len_out   (m_awlen),
        .cache_out (m_awcache),
        .oversize  (aw_oversize)
    );

    axi_ax_convert u_ar_conv (
        .len_in    (s_arlen),
        .cache_in  (s_arcache),
        .len_out   (m_arlen),
        .cache_out (m_arcache),
        .oversize  (ar_oversize)
    );

    // Write-address channel: held off while every WID slot is taken
    assign m_awid    = s_awid;
    assign m_awaddr  = s_awaddr;
    assign m_awsize  = s_awsize;
    assign m_awburst = s_awburst;
    assign m_awlock  = 2'b00;
    assign m_awvalid = s_awvalid && !fifo_full;
    assign s_awready = m_awready && !fifo_full;
    assign aw_fire   = m_awvalid && m_awready;

    // Write-data channel: held off until its burst's address is known
    assign m_wdata  = s_wdata;
    assign m_wstrb  = s_wstrb;
    assign m_wlast  = s_wlast;
    assign m_wvalid = s_wvalid && !fifo_empty;
    assign s_wready = m_wready && !fifo_empty;
    assign w_done   = m_wvalid && m_wready && s_wlast;

    axi_id_fifo #(
        .ID_W  (ID_W),
        .DEPTH (WID_DEPTH)
    ) u_wid_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (aw_fire),
        .push_id (s_awid),
        .pop     (w_done),
        .head_id (m_wid),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    // Read-address channel: never stalled
    assign m_arid    = s_arid;
    assign m_araddr  = s_araddr;
    assign m_arsize  = s_arsize;
    assign m_arburst = s_arburst;
    assign m_arlock  = 2'b00;
    assign m_arvalid = s_arvalid;
    assign s_arready = m_arready;
    assign ar_fire   = s_arvalid && m_arready;

    // Response channels
    assign s_bid    = m_bid;
    assign s_bresp  = m_bresp;
    assign s_bvalid = m_bvalid;
    assign m_bready = s_bready;
    assign s_rid    = m_rid;
    assign s_rdata  = m_rdata;
    assign s_rresp  = m_rresp;
    assign s_rlast  = m_rlast;
    assign s_rvalid = m_rvalid;
    assign m_rready = s_rready;

    // Sticky length-error state machine
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= ERR_CLEAR;
        else        err_q <= err_d;
    end

    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR:   if ((aw_fire && aw_oversize) || (ar_fire && ar_oversize))
                             err_d = ERR_LATCHED;
            ERR_LATCHED: err_d = ERR_LATCHED;
            default:     err_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        len_err = (err_q == ERR_LATCHED);
    end

endmodule

// File: rtl/axi_adapter_chk.sv
module axi_adapter_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       s_awvalid,
    input logic       s_awready,
    input logic [7:0] s_awlen,
    input logic [3:0] s_awcache,
    input logic       s_arvalid,
    input logic       s_arready,
    input logic [7:0] s_arlen,
    input logic       m_awvalid,
    input logic       m_awready,
    input logic [3:0] m_awlen,
    input logic [3:0] m_awcache,
    input logic       m_arvalid,
    input logic [3:0] m_arlen,
    input logic       m_wvalid,
    input logic       m_wready,
    input logic       s_wready,
    input logic       m_wlast,
    input logic [3:0] m_wid,
    input logic       len_err
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 2);
    logic [CNT_W-1:0] pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= pending + CNT_W'(m_awvalid && m_awready)
                               - CNT_W'(m_wvalid && m_wready && m_wlast);
        end
    end

    // R1
    aw_len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && s_awlen > 8'd15) |-> (m_awlen == 4'd15));

    // R1
    ar_len_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && s_arlen <= 8'd15) |-> (m_arlen == s_arlen[3:0]));

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    // R2
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && s_arlen > 8'd15) |=> len_err);

    // R4
    cache_alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !s_awcache[1]) |-> (m_awcache[3:2] == 2'b00));

    // R5
    wid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> $stable(m_wid));

    // R6
    aw_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == CNT_W'(DEPTH)) |-> (!m_awvalid && !s_awready));

    // R7
    w_empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> (!m_wvalid && !s_wready));

endmodule

bind axi4_to_axi3_adapter axi_adapter_chk #(.DEPTH(WID_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_awlen   (s_awlen),
    .s_awcache (s_awcache),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_arlen   (s_arlen),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awlen   (m_awlen),
    .m_awcache (m_awcache),
    .m_arvalid (m_arvalid),
    .m_arlen   (m_arlen),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .s_wready  (s_wready),
    .m_wlast   (m_wlast),
    .m_wid     (m_wid),
    .len_err   (len_err)
);

// File: tb/axi4_to_axi3_adapter_test.sv
`timescale 1ns/1ps
module axi4_to_axi3_adapter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0]  s_awid = '0;  logic [31:0] s_awaddr = '0; logic [7:0] s_awlen = '0;
    logic [2:0]  s_awsize = '0; logic [1:0] s_awburst = '0; logic [3:0] s_awcache = '0;
    logic        s_awvalid = 1'b0; logic s_awready;
    logic [31:0] s_wdata = '0; logic [3:0] s_wstrb = '0; logic s_wlast = 1'b0;
    logic        s_wvalid = 1'b0; logic s_wready;
    logic [3:0]  s_bid; logic [1:0] s_bresp; logic s_bvalid; logic s_bready = 1'b0;
    logic [3:0]  s_arid = '0;  logic [31:0] s_araddr = '0; logic [7:0] s_arlen = '0;
    logic [2:0]  s_arsize = '0; logic [1:0] s_arburst = '0; logic [3:0] s_arcache = '0;
    logic        s_arvalid = 1'b0; logic s_arready;
    logic [3:0]  s_rid; logic [31:0] s_rdata; logic [1:0] s_rresp; logic s_rlast;
    logic        s_rvalid; logic s_rready = 1'b0;
    logic [3:0]  m_awid; logic [31:0] m_awaddr; logic [3:0] m_awlen; logic [2:0] m_awsize;
    logic [1:0]  m_awburst, m_awlock; logic [3:0] m_awcache; logic m_awvalid;
    logic        m_awready = 1'b0;
    logic [3:0]  m_wid; logic [31:0] m_wdata; logic [3:0] m_wstrb; logic m_wlast;
    logic        m_wvalid; logic m_wready = 1'b0;
    logic [3:0]  m_bid = '0; logic [1:0] m_bresp = '0; logic m_bvalid = 1'b0; logic m_bready;
    logic [3:0]  m_arid; logic [31:0] m_araddr; logic [3:0] m_arlen; logic [2:0] m_arsize;
    logic [1:0]  m_arburst, m_arlock; logic [3:0] m_arcache; logic m_arvalid;
    logic        m_arready = 1'b0;
    logic [3:0]  m_rid = '0; logic [31:0] m_rdata = '0; logic [1:0] m_rresp = '0;
    logic        m_rlast = 1'b0; logic m_rvalid = 1'b0; logic m_rready;
    logic        len_err;

    axi4_to_axi3_adapter uut (.*);

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [3:0] exp_wid[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Driver: issue one write address, check the converted fields, log the expected WID
    task automatic send_aw(input logic [3:0] id, input logic [7:0] len, input logic [3:0] cache,
                           input logic [3:0] exp_len, input logic [3:0] exp_cache);
        s_awid = id; s_awaddr = {24'h0, id, 4'h0}; s_awlen = len; s_awcache = cache;
        s_awsize = 3'd2; s_awburst = 2'b01; s_awvalid = 1'b1;
        @(negedge clk);
        while (!s_awready) @(negedge clk);
        chk("R1 awlen", 32'(m_awlen), 32'(exp_len));
        chk("R4 awcache", 32'(m_awcache), 32'(exp_cache));
        chk("R3 awlock", 32'(m_awlock), 32'h0);
        chk("R8 awaddr", m_awaddr, s_awaddr);
        exp_wid.push_back(id);
        step();
        s_awvalid = 1'b0;
    endtask

    task automatic send_w(input int beats);
        for (int i = 0; i < beats; i++) begin
            s_wvalid = 1'b1; s_wlast = (i == beats - 1); s_wdata = 32'hA500 + 32'(i); s_wstrb = 4'hF;
            @(negedge clk);
            while (!s_wready) @(negedge clk);
            chk("R8 wdata", m_wdata, s_wdata);
            step();
        end
        s_wvalid = 1'b0; s_wlast = 1'b0;
    endtask

    // Monitor: every W handshake must carry the WID at the front of the scoreboard
    always @(negedge clk) begin
        if (rst_n && m_wvalid && m_wready) begin
            if (exp_wid.size() == 0) begin
                chk("R5 wid without burst", 32'(m_wid), 32'hFFFF);
            end else begin
                chk("R5 wid order", 32'(m_wid), 32'(exp_wid[0]));
                if (m_wlast) void'(exp_wid.pop_front());
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        @(negedge clk);
        chk("R2 reset clears len_err", 32'(len_err), 32'h0);
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // R7: no write address yet, W must stall
        s_wvalid = 1'b1; m_wready = 1'b1;
        @(negedge clk);
        chk("R7 m_wvalid empty", 32'(m_wvalid), 32'h0);
        chk("R7 s_wready empty", 32'(s_wready), 32'h0);
        step();
        s_wvalid = 1'b0;

        // Read address conversion and pass-through
        s_arid = 4'd6; s_araddr = 32'h1000; s_arlen = 8'd7; s_arcache = 4'b1110;
        s_arvalid = 1'b1; m_arready = 1'b0;
        @(negedge clk);
        chk("R1 arlen short", 32'(m_arlen), 32'd7);
        chk("R4 arcache modifiable", 32'(m_arcache), 32'hE);
        chk("R3 arlock", 32'(m_arlock), 32'h0);
        chk("R8 arid", 32'(m_arid), 32'd6);
        chk("R9 arready low", 32'(s_arready), 32'h0);
        chk("R9 arvalid through", 32'(m_arvalid), 32'h1);
        m_arready = 1'b1;
        #1;
        chk("R9 arready high", 32'(s_arready), 32'h1);
        step();
        s_arlen = 8'd40; s_arcache = 4'b1101; m_arready = 1'b0;
        @(negedge clk);
        chk("R1 arlen clamp", 32'(m_arlen), 32'd15);
        chk("R4 arcache non-modifiable", 32'(m_arcache), 32'h1);
        step();
        @(negedge clk);
        chk("R2 no handshake no error", 32'(len_err), 32'h0);
        m_arready = 1'b1;
        step();
        s_arvalid = 1'b0;
        @(negedge clk);
        chk("R2 error after oversize AR", 32'(len_err), 32'h1);
        repeat (3) step();
        @(negedge clk);
        chk("R2 error sticky", 32'(len_err), 32'h1);

        // Response channels
        m_rvalid = 1'b1; m_rid = 4'd9; m_rdata = 32'hDEAD_BEEF; m_rresp = 2'b10; m_rlast = 1'b1;
        s_rready = 1'b1; m_bvalid = 1'b1; m_bid = 4'd3; m_bresp = 2'b01; s_bready = 1'b1;
        #1;
        chk("R8 rdata", s_rdata, 32'hDEAD_BEEF);
        chk("R8 rid/resp/last/valid", {s_rid, s_rresp, s_rlast, s_rvalid}, {4'd9, 2'b10, 1'b1, 1'b1});
        chk("R8 rready", 32'(m_rready), 32'h1);
        chk("R8 b channel", {s_bid, s_bresp, s_bvalid, m_bready}, {4'd3, 2'b01, 1'b1, 1'b1});
        step();
        m_rvalid = 1'b0; m_bvalid = 1'b0;

        do_reset();

        // Fill the WID FIFO
        m_awready = 1'b1; m_wready = 1'b1;
        send_aw(4'd3, 8'd0, 4'b0011, 4'd0, 4'b0011);
        send_aw(4'd5, 8'd3, 4'b1111, 4'd3, 4'b1111);
        send_aw(4'd9, 8'd20, 4'b1100, 4'd15, 4'b0000);
        send_aw(4'd12, 8'd15, 4'b0110, 4'd15, 4'b0110);
        @(negedge clk);
        chk("R2 error after oversize AW", 32'(len_err), 32'h1);
        s_awvalid = 1'b1; s_awid = 4'd7;
        @(negedge clk);
        chk("R6 m_awvalid full", 32'(m_awvalid), 32'h0);
        chk("R6 s_awready full", 32'(s_awready), 32'h0);
        step();
        s_awvalid = 1'b0;

        send_w(1);
        @(negedge clk);
        chk("R6 slot freed", 32'(s_awready), 32'h1);
        send_w(4);
        send_w(16);
        send_w(16);

        s_wvalid = 1'b1;
        @(negedge clk);
        chk("R7 drained stall", 32'(m_wvalid), 32'h0);
        step();
        s_wvalid = 1'b0;

        // Data ahead of its address
        fork
            send_w(2);
            begin
                repeat (3) step();
                send_aw(4'd11, 8'd1, 4'b1010, 4'd1, 4'b1010);
            end
        join
        repeat (2) step();
        chk("R5 scoreboard drained", 32'(exp_wid.size()), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule